// File: doc/BRIEF.md
# Configuration Request Retry Sequencer

This block sits beside a PCI Express configuration requester and decides what happens when a configuration request comes back with Configuration Request Retry Status (CRS). A host pulses `start_i`, the block asks the requester to send the request with `issue_o`, and the requester returns each completion's status on `cpl_valid_i` / `cpl_status_i`. A completion other than CRS ends the sequence at once. A CRS completion either ends it as a failure, when retries are switched off, or makes the block send the request again. Retries stop when a timeout counter runs out.

The block holds one 32-bit control word. Bit 0 switches retries off. Bits 3:1 always read as zero. Bits 31:4 hold the timeout load value, counted in units of eight clocks. The first CRS completion of a request loads the counter from that field, and later CRS completions of the same request do not reload it. At the start of each request the block takes a copy of the control word, so writes made while a request is in flight apply only from the next request. The outcome is reported as a one-cycle `done_o` pulse with a status code.

Top module: `cfg_retry_ctrl`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x400FFFF0: the timeout field is 0x400FFFF and the retry-off bit is 0. `busy_o`, `issue_o` and `done_o` are low.
- R2: A write with `cfg_wr_en` stores the word, and it reads back on the next cycle with bits 3:1 forced to zero. Bit 0 is the retry-off bit and bits 31:4 are the timeout field.
- R3: `start_i` while idle raises `busy_o` and gives a one-cycle `issue_o` pulse on the next cycle. `start_i` while busy is ignored and causes no `issue_o`.
- R4: A completion whose status is not CRS ends the request. `done_o` pulses on the next cycle, with `done_status_o` equal to the received code. The status codes are: 000 success, 001 unsupported, 010 CRS, 100 aborted.
- R5: With the retry-off bit at 1, a CRS completion ends the request on the next cycle with `done_status_o` = 010, and no request is sent again.
- R6: With the retry-off bit at 0 and the timer not expired, a CRS completion is followed on the next cycle by a new `issue_o` pulse.
- R7: The first CRS completion of a request loads the timer from the timeout field TC, and later CRS completions do not reload it. The timer counts down once every 8 clocks and expires 8×(TC+1) clocks after the edge that loaded it. If the requester answers each issue two clocks later with CRS, a request sends 4×(TC+1)+2 issues in total.
- R8: A CRS completion that arrives after the timer has expired ends the request with `done_status_o` = 111, which means timeout.
- R9: With a timeout field of 0, the timer expires on the first prescaler tick, 8 clocks after the first CRS completion.
- R10: A control word write made during a request does not change that request's behaviour. It applies from the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wr_data | input | 32 | Control word write value |
| cfg_rd_data | output | 32 | Control word read value |
| start_i | input | 1 | Begin a configuration request |
| busy_o | output | 1 | A request sequence is in progress |
| issue_o | output | 1 | Send (or resend) the request now |
| cpl_valid_i | input | 1 | A completion has arrived |
| cpl_status_i | input | 3 | Completion status code |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| done_status_o | output | 3 | Final status: the completion's code, or 111 for timeout |

## Verification
The in-RTL assertions check several rules on every cycle. Each non-CRS completion must be passed through on the next cycle. Each CRS completion with retries off must fail. A timeout report is only allowed after the timer has expired. The prescaler tick may never be high on two cycles in a row. The timer may only change value on a tick, a load or a clear, and it may only expire right after a tick. Other behaviour shows up only in the bench's scenarios: the exact number of reissues before timeout for a given field value, the absence of a reload on later CRS completions, and the effect of writes made in the middle of a request.

// File: rtl/cfg_retry_pkg.sv
package cfg_retry_pkg;
    localparam int STAT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    localparam logic [STAT_W-1:0] CPL_SC   = 3'b000;
    localparam logic [STAT_W-1:0] CPL_UR   = 3'b001;
    localparam logic [STAT_W-1:0] CPL_CRS  = 3'b010;
    localparam logic [STAT_W-1:0] CPL_CA   = 3'b100;
    localparam logic [STAT_W-1:0] DONE_TMO = 3'b111;
endpackage

// File: rtl/cfg_retry_regs.sv
module cfg_retry_regs #(
    parameter int               TC_W   = 28,
    parameter logic [TC_W-1:0]  TC_RST = 28'h400_FFFF,
    localparam int              REG_W  = TC_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             retry_off,
    output logic [TC_W-1:0]  tc_val
);
    typedef struct packed {
        logic            off;
        logic [TC_W-1:0] tc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            r_d.off = wr_data[0];
            r_d.tc  = wr_data[REG_W-1:4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.off <= 1'b0;
            r_q.tc  <= TC_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data   = {r_q.tc, 3'b000, r_q.off};
    assign retry_off = r_q.off;
    assign tc_val    = r_q.tc;

    // R2: written word is visible one cycle later with reserved bits cleared
    p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == {$past(wr_data[REG_W-1:4]), 3'b000, $past(wr_data[0])});
endmodule

// File: rtl/cfg_retry_prescale.sv
module cfg_retry_prescale #(
    parameter int PRE_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    output logic tick
);
    logic [PRE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)       cnt_d = '0;
        else if (enable) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = enable && (cnt_q == {PRE_W{1'b1}});

    // R7: ticks are spaced by the prescale period, never back to back
    p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/cfg_retry_timer.sv
module cfg_retry_timer #(
    parameter int TC_W = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            clear,
    input  logic            tick,
    input  logic [TC_W-1:0] load_val,
    output logic            running,
    output logic            expired
);
    typedef struct packed {
        logic            run;
        logic            exp;
        logic [TC_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clear) begin
            t_d.run = 1'b0;
            t_d.exp = 1'b0;
        end else if (load) begin
            t_d.run = 1'b1;
            t_d.exp = 1'b0;
            t_d.cnt = load_val;
        end else if (t_q.run && tick && !t_q.exp) begin
            if (t_q.cnt == '0) t_d.exp = 1'b1;
            else               t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.run <= 1'b0;
            t_q.exp <= 1'b0;
            t_q.cnt <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign running = t_q.run;
    assign expired = t_q.exp;

    // R7: without a tick, load or clear the count stays put
    p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.run && !tick && !load && !clear) |=> $stable(t_q.cnt) && $stable(t_q.exp));
endmodule

// File: rtl/cfg_retry_ctrl.sv
module cfg_retry_ctrl
    import cfg_retry_pkg::*;
#(
    parameter int              TC_W   = 28,
    parameter int              PRE_W  = 3,
    parameter logic [TC_W-1:0] TC_RST = 28'h400_FFFF,
    localparam int             REG_W  = TC_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_W-1:0]  cfg_wr_data,
    output logic [REG_W-1:0]  cfg_rd_data,
    input  logic              start_i,
    output logic              busy_o,
    output logic              issue_o,
    input  logic              cpl_valid_i,
    input  logic [STAT_W-1:0] cpl_status_i,
    output logic              done_o,
    output logic [STAT_W-1:0] done_status_o
);
    typedef struct packed {
        seq_state_e        state;
        logic              off;
        logic [TC_W-1:0]   tc;
        logic              crs_seen;
        logic              done;
        logic [STAT_W-1:0] status;
    } seq_t;

    seq_t s_d, s_q;

    logic            reg_off;
    logic [TC_W-1:0] reg_tc;
    logic            tmr_load, tmr_clear, tmr_run, tmr_exp, pre_tick;

    cfg_retry_regs #(.TC_W(TC_W), .TC_RST(TC_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
        .rd_data(cfg_rd_data), .retry_off(reg_off), .tc_val(reg_tc)
    );

    cfg_retry_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clear(tmr_load | tmr_clear),
        .enable(tmr_run), .tick(pre_tick)
    );

    cfg_retry_timer #(.TC_W(TC_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .clear(tmr_clear),
        .tick(pre_tick), .load_val(s_q.tc), .running(tmr_run), .expired(tmr_exp)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        tmr_load  = 1'b0;
        tmr_clear = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.state    = ST_ISSUE;
                    s_d.off      = reg_off;
                    s_d.tc       = reg_tc;
                    s_d.crs_seen = 1'b0;
                end
            end
            ST_ISSUE: s_d.state = ST_WAIT;
            ST_WAIT: begin
                if (cpl_valid_i) begin
                    if (cpl_status_i != CPL_CRS) begin
                        s_d.state  = ST_IDLE;
                        s_d.done   = 1'b1;
                        s_d.status = cpl_status_i;
                        tmr_clear  = 1'b1;
                    end else if (s_q.off) begin
                        s_d.state  = ST_IDLE;
                        s_d.done   = 1'b1;
                        s_d.status = CPL_CRS;
                        tmr_clear  = 1'b1;
                    end else if (!s_q.crs_seen) begin
                        s_d.state    = ST_ISSUE;
                        s_d.crs_seen = 1'b1;
                        tmr_load     = 1'b1;
                    end else if (tmr_exp) begin
                        s_d.state  = ST_IDLE;
                        s_d.done   = 1'b1;
                        s_d.status = DONE_TMO;
                        tmr_clear  = 1'b1;
                    end else begin
                        s_d.state = ST_ISSUE;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.state    <= ST_IDLE;
            s_q.off      <= 1'b0;
            s_q.tc       <= '0;
            s_q.crs_seen <= 1'b0;
            s_q.done     <= 1'b0;
            s_q.status   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o        = (s_q.state != ST_IDLE);
    assign issue_o       = (s_q.state == ST_ISSUE);
    assign done_o        = s_q.done;
    assign done_status_o = s_q.status;

    // R3: each send request lasts exactly one cycle
    p_issue_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_o |=> !issue_o);

    // R4: non-CRS completion is reported unchanged on the next cycle
    p_pass_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WAIT && cpl_valid_i && cpl_status_i != CPL_CRS)
        |=> done_o && done_status_o == $past(cpl_status_i));

    // R5: CRS with retries switched off fails without a resend
    p_off_fails_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_WAIT && cpl_valid_i && cpl_status_i == CPL_CRS && s_q.off)
        |=> done_o && done_status_o == CPL_CRS && !issue_o);

    // R8: timeout is only reported once the timer had expired
    p_tmo_after_exp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && done_status_o == DONE_TMO) |-> $past(tmr_exp));

    // R9: expiry follows a prescaler tick
    p_exp_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_exp) |-> $past(pre_tick));
endmodule

// File: tb/sim_cfg_retry_ctrl.sv
module sim_cfg_retry_ctrl;
    localparam logic [2:0] SC = 3'b000, UR = 3'b001, CRS = 3'b010, CA = 3'b100, TMO = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic [31:0] cfg_rd_data;
    logic        start_i = 1'b0;
    logic        busy_o, issue_o, done_o;
    logic        cpl_valid_i = 1'b0;
    logic [2:0]  cpl_status_i = '0;
    logic [2:0]  done_status_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    cfg_retry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .start_i(start_i), .busy_o(busy_o), .issue_o(issue_o),
        .cpl_valid_i(cpl_valid_i), .cpl_status_i(cpl_status_i), .done_o(done_o),
        .done_status_o(done_status_o)
    );

    // {exp_issues[12:9], exp_status[8:6], crs_before[5:4], final[3:1], retry_off[0]}
    localparam logic [12:0] VECS [7] = '{
        {4'd1, SC,  2'd0, SC,  1'b0},
        {4'd1, UR,  2'd0, UR,  1'b0},
        {4'd1, CA,  2'd0, CA,  1'b0},
        {4'd1, CRS, 2'd0, CRS, 1'b1},
        {4'd2, SC,  2'd1, SC,  1'b0},
        {4'd3, UR,  2'd2, UR,  1'b0},
        {4'd1, SC,  2'd0, SC,  1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [31:0] v);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic serve(input int n_crs, input logic [2:0] fin,
                         output int issues, output logic [2:0] st, output logic got);
        issues = 0; st = '0; got = 1'b0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        for (int g = 0; g < 4000 && !got; g++) begin
            if (issue_o) begin
                issues++;
                @(negedge clk);
                cpl_valid_i = 1'b1;
                cpl_status_i = (issues <= n_crs) ? CRS : fin;
                @(negedge clk);
                cpl_valid_i = 1'b0;
                if (done_o) begin got = 1'b1; st = done_status_o; end
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int n; logic [2:0] st; logic got; logic [12:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset word", cfg_rd_data, 32'h400F_FFF0);
        chk("R1 idle outputs", {busy_o, issue_o, done_o}, 3'b000);

        // R2 write and reserved bits
        wr_reg(32'hFFFF_FFFF);
        chk("R2 reserved read zero", cfg_rd_data, 32'hFFFF_FFF1);
        wr_reg(32'h0000_0021);
        chk("R2 readback", cfg_rd_data, 32'h0000_0021);

        // vector table: R4 R5 R6
        for (int i = 0; i < 7; i++) begin
            v = VECS[i];
            wr_reg({28'h10, 3'b000, v[0]});
            serve(int'(v[5:4]), v[3:1], n, st, got);
            chk("R4/R5/R6 vector done", {31'b0, got}, 32'd1);
            chk("R4/R5/R6 vector status", {29'b0, st}, {29'b0, v[8:6]});
            chk("R6 vector issue count", n, int'(v[12:9]));
        end

        // R9 timeout field zero
        wr_reg(32'h0000_0000);
        serve(100000, SC, n, st, got);
        chk("R9 tc0 status", {29'b0, st}, {29'b0, TMO});
        chk("R9 tc0 issues", n, 6);

        // R7 R8 no reload on later CRS
        wr_reg(32'h0000_0020);
        serve(100000, SC, n, st, got);
        chk("R8 timeout status", {29'b0, st}, {29'b0, TMO});
        chk("R7 issues before expiry", n, 14);
        chk("R8 idle after timeout", {31'b0, busy_o}, 32'd0);

        // R3 start while busy is ignored
        wr_reg(32'h0000_0100);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk("R3 first issue", {busy_o, issue_o}, 2'b11);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        chk("R3 no issue on busy start", {busy_o, issue_o}, 2'b10);
        cpl_valid_i = 1'b1; cpl_status_i = SC;
        @(negedge clk); cpl_valid_i = 1'b0;
        chk("R3 done after busy start", {done_o, done_status_o}, {1'b1, SC});
        @(negedge clk);
        chk("R3 no restart", {busy_o, issue_o}, 2'b00);

        // R10 write during sequence takes effect later
        wr_reg(32'h0000_0100);
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        cfg_wr_en = 1'b1; cfg_wr_data = 32'h0000_0001;
        @(negedge clk); cfg_wr_en = 1'b0;
        cpl_valid_i = 1'b1; cpl_status_i = CRS;
        @(negedge clk); cpl_valid_i = 1'b0;
        chk("R10 retried despite write", {done_o, issue_o}, 2'b01);
        @(negedge clk);
        cpl_valid_i = 1'b1; cpl_status_i = SC;
        @(negedge clk); cpl_valid_i = 1'b0;
        chk("R10 finishes success", {done_o, done_status_o}, {1'b1, SC});
        serve(5, SC, n, st, got);
        chk("R10 next request uses write", {29'b0, st}, {29'b0, CRS});
        chk("R10 next request single issue", n, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule